// File: doc/BRIEF.md
# Dual Programmable Interval Timer

The block contains two independent down-counting timer channels that share one interrupt collection stage and one 32-bit register window. Each channel owns a reload value, a live counter that software can read, and a control word. The control word carries a two-bit command that loads, freezes or runs the counter. It also carries a three-bit source code that picks which of four tick-enable inputs advances the counter. Clock sources are not generated here. They arrive as single-cycle enable strobes at four different rates, all in the block's own clock domain.

A running channel subtracts one from its counter on each cycle where its chosen strobe is high. A strobe that finds the counter at one or zero reloads the reload value and flags an expiry. Each expiry latches a sticky bit in a two-bit raw status word. Software masks that word, reads a masked copy of it and clears bits by writing ones to an acknowledge address. The single interrupt line is the OR of the masked bits. Register access is a single-cycle write strobe with a combinational read port, both full 32-bit words.

Top module: `dual_interval_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both channels stop and the reload values, counters, control words, raw status and mask are cleared. `irq` is low from the next cycle.
- R2: A control write whose bits [1:0] equal 0 copies the channel's reload value into its counter and leaves the channel stopped.
- R3: A control write whose bits [1:0] equal 1 or 3 stops the channel. A stopped channel's counter keeps its value whatever the tick inputs do.
- R4: After a control write whose bits [1:0] equal 2, the counter drops by one at each edge where the selected tick is high. In a cycle that also carries a control write to the channel, the control write wins and the tick is not counted.
- R5: Control bits [4:2] select the source. Code 4+k selects `tick_src[k]` for k = 0..3, and codes 0 to 3 select no source, so a running counter does not move. Control bits above bit 4 are not stored and read as zero.
- R6: A counted tick that finds the counter at 1 or 0 reloads the reload value and, at the same edge, sets raw status bit 0 for channel 0 or bit 1 for channel 1.
- R7: A write to a reload register does not change the counter. The new value is used at the next load command or reload.
- R8: Writing to the acknowledge register clears each raw status bit whose write-data bit is 1 (bits [1:0]). An expiry at the same edge still sets its bit. The acknowledge register reads as zero.
- R9: The masked status register reads raw status AND mask (bits [1:0]). `irq` is high exactly when that value is non-zero, following every mask write, acknowledge or expiry by one edge.
- R10: Byte offsets: channel 0 reload 0x00, counter 0x04, control 0x08; channel 1 at the same offsets plus 0x10; mask 0x48; acknowledge 0x4C; raw status 0x50; masked status 0x54. Writes to counter and status offsets are ignored. Any other address, misaligned ones included, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_src | input | 4 | Tick-enable strobes, one per source rate |
| bus_wr | input | 1 | Write strobe for one full word |
| bus_addr | input | 7 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
A counter that slips or loses its running flag shows at the counter register in the very next cycle after a tick. It also shows as an expiry arriving one strobe early or late, which turns up in raw status and on `irq` one edge later. A wrong mask or sticky status bit shows on `irq` in the cycle that follows the mask write, acknowledge or expiry, and `irq` is compared against a bench model in every cycle. Misrouted source selection stays hidden until a tick arrives on the wrong input, so random stimulus drives all four strobes independently under all eight source codes.

// File: rtl/dit_pkg.sv
// Shared constants for the dual interval timer: command codes, the
// tick-source numbering and the register byte offsets.
package dit_pkg;
    localparam int NUM_CH    = 2;     // channels in the block
    localparam int SRC_BASE  = 4;     // first source code that selects a tick input
    localparam int CH_STRIDE = 'h10;  // byte distance between channel windows

    localparam int OFF_DIV   = 'h00;  // reload value, per channel
    localparam int OFF_CNT   = 'h04;  // live counter, per channel
    localparam int OFF_CTL   = 'h08;  // control word, per channel
    localparam int OFF_MASK  = 'h48;  // interrupt mask
    localparam int OFF_ACK   = 'h4C;  // write-one-to-clear
    localparam int OFF_RAW   = 'h50;  // raw sticky status
    localparam int OFF_MST   = 'h54;  // masked status

    typedef enum logic [1:0] {
        CMD_LOAD  = 2'd0,
        CMD_HOLD  = 2'd1,
        CMD_RUN   = 2'd2,
        CMD_HOLD2 = 2'd3
    } cmd_e;
endpackage

// File: rtl/dit_channel.sv
// One down-counting timer channel.
// Holds the reload value, the control word and the live counter. A control
// write applies its command at once and takes priority over a tick in the
// same cycle. Assumes tick_src strobes are synchronous to clk.
module dit_channel
    import dit_pkg::*;
#(
    parameter int W    = 32,
    parameter int NSRC = 4,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            div_wr,
    input  logic            ctl_wr,
    input  logic [W-1:0]    wdata,
    input  logic [NSRC-1:0] tick_src,
    output logic [W-1:0]    div_q,
    output logic [CW-1:0]   ctl_q,
    output logic [W-1:0]    count_q,
    output logic            running,
    output logic            expire
);
    localparam int SEL_W = CW - 2;

    logic [SEL_W-1:0] sel;
    logic             tick;
    logic             step;
    logic             at_end;
    cmd_e             new_cmd;

    assign sel     = ctl_q[CW-1:2];
    assign new_cmd = cmd_e'(wdata[1:0]);

    // Pick the tick strobe named by the source field; low codes pick none.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(SRC_BASE + i)) tick = tick_src[i];
        end
    end

    assign step   = running && tick && !ctl_wr;
    assign at_end = (count_q[W-1:1] == '0);
    assign expire = step && at_end;

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= wdata;
    end

    // Control word and the running flag it implies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            running <= 1'b0;
        end else if (ctl_wr) begin
            ctl_q   <= wdata[CW-1:0];
            running <= (new_cmd == CMD_RUN);
        end
    end

    // Live counter: load command, counted tick, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                              count_q <= '0;
        else if (ctl_wr && new_cmd == CMD_LOAD)  count_q <= div_q;
        else if (expire)                         count_q <= div_q;
        else if (step)                           count_q <= count_q - W'(1);
    end
endmodule

// File: rtl/dit_irq.sv
// Interrupt collection for all channels.
// Keeps sticky raw status bits, the mask, and forms the level output.
// An expiry at the same edge as an acknowledge keeps its bit set.
module dit_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_wr,
    input  logic           ack_wr,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] raw_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] masked,
    output logic           irq
);
    logic [NCH-1:0] clr;

    assign clr = ack_wr ? wdata : '0;

    // Sticky status: clear acknowledged bits, then set new expiries.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr) | expire;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata;
    end

    assign masked = raw_q & mask_q;
    assign irq    = |masked;
endmodule

// File: rtl/dit_decode.sv
// Register window decode: write strobes per register and the read mux.
// Assumes full-word accesses; an address must match exactly, so
// misaligned and unmapped addresses read zero and write nothing.
module dit_decode
    import dit_pkg::*;
#(
    parameter int W   = 32,
    parameter int AW  = 7,
    parameter int NCH = 2,
    parameter int CW  = 5
) (
    input  logic                   wr,
    input  logic [AW-1:0]          addr,
    input  logic [NCH-1:0][W-1:0]  div_all,
    input  logic [NCH-1:0][W-1:0]  cnt_all,
    input  logic [NCH-1:0][CW-1:0] ctl_all,
    input  logic [NCH-1:0]         raw_q,
    input  logic [NCH-1:0]         mask_q,
    input  logic [NCH-1:0]         masked,
    output logic [NCH-1:0]         div_wr,
    output logic [NCH-1:0]         ctl_wr,
    output logic                   mask_wr,
    output logic                   ack_wr,
    output logic [W-1:0]           rdata
);
    // Per-channel write strobes.
    for (genvar c = 0; c < NCH; c++) begin : g_wstb
        assign div_wr[c] = wr && (addr == AW'(c * CH_STRIDE + OFF_DIV));
        assign ctl_wr[c] = wr && (addr == AW'(c * CH_STRIDE + OFF_CTL));
    end

    assign mask_wr = wr && (addr == AW'(OFF_MASK));
    assign ack_wr  = wr && (addr == AW'(OFF_ACK));

    // Read multiplexer; anything unmatched returns zero.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(c * CH_STRIDE + OFF_DIV)) rdata = div_all[c];
            if (addr == AW'(c * CH_STRIDE + OFF_CNT)) rdata = cnt_all[c];
            if (addr == AW'(c * CH_STRIDE + OFF_CTL)) rdata = W'(ctl_all[c]);
        end
        if (addr == AW'(OFF_MASK)) rdata = W'(mask_q);
        if (addr == AW'(OFF_RAW))  rdata = W'(raw_q);
        if (addr == AW'(OFF_MST))  rdata = W'(masked);
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Two interval timer channels behind one word-wide register window with a
// shared mask / acknowledge interrupt stage and one level interrupt.
// Assumes tick_src strobes come from the clk domain and that every access
// is a full 32-bit word.
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7,
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);
    localparam int SEL_W = $clog2(SRC_BASE + NUM_SRC);
    localparam int CW    = 2 + SEL_W;

    logic [NUM_CH-1:0][DATA_W-1:0] div_all;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_all;
    logic [NUM_CH-1:0][CW-1:0]     ctl_all;
    logic [NUM_CH-1:0]             div_wr;
    logic [NUM_CH-1:0]             ctl_wr;
    logic [NUM_CH-1:0]             expire;
    logic [NUM_CH-1:0]             running;
    logic [NUM_CH-1:0]             raw_q;
    logic [NUM_CH-1:0]             mask_q;
    logic [NUM_CH-1:0]             masked;
    logic                          mask_wr;
    logic                          ack_wr;

    dit_decode #(.W(DATA_W), .AW(ADDR_W), .NCH(NUM_CH), .CW(CW)) u_dec (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .div_all (div_all),
        .cnt_all (cnt_all),
        .ctl_all (ctl_all),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .div_wr  (div_wr),
        .ctl_wr  (ctl_wr),
        .mask_wr (mask_wr),
        .ack_wr  (ack_wr),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dit_channel #(.W(DATA_W), .NSRC(NUM_SRC), .CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (div_wr[g]),
            .ctl_wr   (ctl_wr[g]),
            .wdata    (bus_wdata),
            .tick_src (tick_src),
            .div_q    (div_all[g]),
            .ctl_q    (ctl_all[g]),
            .count_q  (cnt_all[g]),
            .running  (running[g]),
            .expire   (expire[g])
        );
    end

    dit_irq #(.NCH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .ack_wr  (ack_wr),
        .wdata   (bus_wdata[NUM_CH-1:0]),
        .expire  (expire),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq)
    );
endmodule

// File: rtl/dit_checker.sv
// Temporal checks on the interval timer, attached by bind below.
// Assumes the default register offsets from dit_pkg.
module dit_checker
    import dit_pkg::*;
#(
    parameter int W   = 32,
    parameter int AW  = 7,
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] wbits,
    input logic [NCH-1:0] raw_q,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] expire,
    input logic [NCH-1:0] running,
    input logic [W-1:0]   cnt0,
    input logic           irq
);
    logic ctl0_w, ack_w, mask_w;
    assign ctl0_w = bus_wr && (bus_addr == AW'(OFF_CTL));
    assign ack_w  = bus_wr && (bus_addr == AW'(OFF_ACK));
    assign mask_w = bus_wr && (bus_addr == AW'(OFF_MASK));

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0 && !irq && running == '0));

    p_stopped_count_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running[0] && !ctl0_w) |=> $stable(cnt0));

    p_expire_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |-> running[0]);

    p_expire_sets_raw0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> raw_q[0]);

    p_expire_sets_raw1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire[1] |=> raw_q[1]);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && wbits[1] && !expire[1]) |=> !raw_q[1]);

    p_zero_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w && wbits == '0) |=> !irq);
endmodule

bind dual_interval_timer dit_checker #(.W(DATA_W), .AW(ADDR_W), .NCH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbits    (bus_wdata[NUM_CH-1:0]),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .expire   (expire),
    .running  (running),
    .cnt0     (cnt_all[0]),
    .irq      (irq)
);

// File: tb/tb_dual_interval_timer.sv
// Bench: directed corner cases followed by seeded random traffic, all
// compared against a cycle model built from the requirements.
module tb_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [31:0] m_div [2];
    logic [31:0] m_cnt [2];
    logic [4:0]  m_ctl [2];
    bit          m_run [2];
    logic [1:0]  m_raw, m_mask;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_div[c] = '0; m_cnt[c] = '0; m_ctl[c] = '0; m_run[c] = 0;
        end
        m_raw = '0; m_mask = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [6:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < 2; c++) begin
            if (a == 7'(16 * c))     r = m_div[c];
            if (a == 7'(16 * c + 4)) r = m_cnt[c];
            if (a == 7'(16 * c + 8)) r = 32'(m_ctl[c]);
        end
        if (a == 7'h48) r = 32'(m_mask);
        if (a == 7'h50) r = 32'(m_raw);
        if (a == 7'h54) r = 32'(m_raw & m_mask);
        return r;
    endfunction

    task automatic model_step(input logic w, input logic [6:0] a,
                              input logic [31:0] d, input logic [3:0] t);
        logic [1:0] ex = '0;
        for (int c = 0; c < 2; c++) begin
            bit cw = w && (a == 7'(16 * c + 8));
            bit dw = w && (a == 7'(16 * c));
            int sel = int'(m_ctl[c][4:2]);
            bit tk = (sel >= 4) ? t[sel - 4] : 1'b0;
            if (cw) begin
                m_ctl[c] = d[4:0];
                m_run[c] = (d[1:0] == 2'd2);
                if (d[1:0] == 2'd0) m_cnt[c] = m_div[c];
            end else if (m_run[c] && tk) begin
                if (m_cnt[c] <= 1) begin
                    m_cnt[c] = m_div[c];
                    ex[c] = 1'b1;
                end else begin
                    m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (dw) m_div[c] = d;
        end
        if (w && a == 7'h4C) m_raw = m_raw & ~d[1:0];
        m_raw = m_raw | ex;
        if (w && a == 7'h48) m_mask = d[1:0];
    endtask

    // One bus cycle: drive at the falling edge, check mid-phase, advance model.
    task automatic cyc(input logic w, input logic [6:0] a, input logic [31:0] d,
                       input logic [3:0] t, input bit chk, input string tag);
        logic [31:0] exp_rd;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_src = t;
        #5;
        checks++;
        if (irq !== |(m_raw & m_mask)) begin
            fails++;
            $display("FAIL R9: irq got %b expected %b", irq, |(m_raw & m_mask));
        end
        if (chk) begin
            exp_rd = model_read(a);
            checks++;
            if (bus_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s: addr %h read %h expected %h", tag, a, bus_rdata, exp_rd);
            end
        end
        model_step(w, a, d, t);
        @(posedge clk);
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        cyc(1'b0, a, 32'h0, 4'h0, 1'b1, tag);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] t);
        cyc(1'b1, a, d, t, 1'b0, "");
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic string tag_of(input logic [6:0] a);
        case (a)
            7'h00, 7'h10:         return "R7";
            7'h04, 7'h14:         return "R4";
            7'h08, 7'h18:         return "R5";
            7'h48, 7'h54:         return "R9";
            7'h4C:                return "R8";
            7'h50:                return "R6";
            default:              return "R10";
        endcase
    endfunction

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [6:0] alist [12] = '{7'h00, 7'h04, 7'h08, 7'h10, 7'h14, 7'h18,
                                   7'h48, 7'h4C, 7'h50, 7'h54, 7'h20, 7'h3D};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(7'h50, "R1"); rd(7'h48, "R1"); rd(7'h04, "R1"); rd(7'h18, "R1");

        // R10: map, read-only and unmapped accesses
        wr(7'h00, 32'd5, 4'h0);
        rd(7'h00, "R10");
        wr(7'h04, 32'd77, 4'h0);
        rd(7'h04, "R10");
        wr(7'h20, 32'hFFFF_FFFF, 4'h0);
        rd(7'h20, "R10");
        rd(7'h01, "R10");
        wr(7'h50, 32'h3, 4'h0);
        rd(7'h50, "R10");

        // R2: load command with source code 4
        wr(7'h08, 32'h10, 4'h0);
        rd(7'h04, "R2");
        wr(7'h08, 32'hFFFF_FF10, 4'h0);
        rd(7'h08, "R5");

        // R4: run, two ticks on source 0
        wr(7'h08, 32'h12, 4'h1);
        wr(7'h4C, 32'h0, 4'h1);
        wr(7'h4C, 32'h0, 4'h1);
        rd(7'h04, "R4");
        // R5: strobes on other inputs do not count
        wr(7'h4C, 32'h0, 4'hE);
        rd(7'h04, "R5");

        // R3: hold codes 1 and 3
        wr(7'h08, 32'h11, 4'h1);
        wr(7'h4C, 32'h0, 4'hF);
        rd(7'h04, "R3");
        wr(7'h08, 32'h13, 4'hF);
        wr(7'h4C, 32'h0, 4'hF);
        rd(7'h04, "R3");

        // R5: running with disabled source code 2
        wr(7'h08, 32'h0A, 4'hF);
        wr(7'h4C, 32'h0, 4'hF);
        wr(7'h4C, 32'h0, 4'hF);
        rd(7'h04, "R5");

        // R7, R6, R9: reload change while running, then expiry
        wr(7'h48, 32'h1, 4'h0);
        wr(7'h08, 32'h12, 4'h0);
        wr(7'h00, 32'd9, 4'h1);
        rd(7'h04, "R7");
        wr(7'h4C, 32'h0, 4'h1);
        wr(7'h4C, 32'h0, 4'h1);
        rd(7'h04, "R6");
        rd(7'h50, "R6");
        rd(7'h54, "R9");

        // R8: acknowledge with zero, then with one
        wr(7'h4C, 32'h0, 4'h0);
        rd(7'h50, "R8");
        wr(7'h4C, 32'h1, 4'h0);
        rd(7'h50, "R8");
        rd(7'h4C, "R8");

        // R8: expiry on channel 1 in the same cycle as its acknowledge
        wr(7'h10, 32'd1, 4'h0);
        wr(7'h18, 32'h14, 4'h0);
        wr(7'h18, 32'h16, 4'h0);
        wr(7'h4C, 32'h2, 4'h2);
        rd(7'h50, "R8");
        wr(7'h48, 32'h2, 4'h0);
        rd(7'h54, "R9");
        wr(7'h48, 32'h0, 4'h0);
        rd(7'h54, "R9");

        // Seeded random traffic over the whole map
        for (int i = 0; i < 4000; i++) begin
            logic [6:0]  a = alist[$urandom_range(11, 0)];
            logic [31:0] d = $urandom();
            bit          w = ($urandom_range(1, 0) == 1);
            logic [3:0]  t = 4'($urandom());
            if (a == 7'h08 || a == 7'h18) d = d & 32'h1F;
            if (a == 7'h00 || a == 7'h10) d = d & 32'h7;
            cyc(w, a, d, t, ($urandom_range(1, 0) == 1), tag_of(a));
        end

        summary();
        $finish;
    end
endmodule